// File: doc/BRIEF.md
# Indexed-Reset Dual-Read Register File

This block is the general-purpose register store of a small processor datapath. It keeps thirty-two 8-bit words. Two read ports are purely combinational: an address on either port shows up as data within the same cycle. A single write port updates one word on the rising clock edge.

The two read ports are meant to be driven by the two source-register fields of an instruction. The write port takes the destination field and the result value.

Reset is synchronous. It does not clear the file. Instead, each word is loaded with its own address (word 5 holds 5, word 31 holds 31), so a program can use known, distinct operand values straight after reset without an initialisation loop. Word 0 is a constant zero: writes to it are discarded and reads of it always return zero.

Top module: `regfile_idx`

## Requirements
- R1: The file holds 32 independent 8-bit words selected by 5-bit addresses. A distinct value written to each of addresses 1..31 is read back unchanged from each of them.
- R2: At a rising edge with `rst` high, every word n in 1..31 is loaded with the value n.
- R3: Reading address 0 on either port returns 8'h00 at all times, including straight after reset.
- R4: At a rising edge with `rst` low, `wr_en` high and `wr_addr` nonzero, word `wr_addr` takes `wr_data`. A read of that address returns the new value from that edge onward.
- R5: With `wr_en` low, no word changes at a rising edge, whatever `wr_addr` and `wr_data` carry.
- R6: A write to address 0 has no effect. Reading address 0 still returns 8'h00.
- R7: The two read ports are independent. In any cycle each returns the word at its own address, including when both select the same address.
- R8: Reads have no bypass. While a write to address k is pending in a cycle, a read of k in that cycle returns the value stored before the edge.
- R9: When `rst` and a write are both active at one edge, reset wins. The target word holds its index after that edge.
- R10: Reset acts only at the clock edge. While `rst` is high before the edge, the reads still return the previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads each word with its index |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr_a | input | 5 | Read port A address |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_a | output | 8 | Read port A data, combinational |
| rd_data_b | output | 8 | Read port B data, combinational |

## Verification
The properties assume that every input carries a known 0 or 1 value. They also assume that one reset edge happens before anything is judged, because the words hold no defined value until that first reset. The checker enables itself only after it has seen `rst` high at an edge.

The stimulus starts with a reset cycle and drives every input to a defined value from time zero. All input changes are made just after a rising edge, so each edge sees settled addresses, data and enables.

// File: rtl/regfile_idx.sv
module regfile_idx #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word [DEPTH];

  assign word[0] = '0;

  for (genvar g = 1; g < DEPTH; g++) begin : g_word
    localparam logic [DATA_W-1:0] INIT = DATA_W'(g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= INIT;
      else if (wr_en && wr_addr == ADDR_W'(g))
        q <= wr_data;
    end
    assign word[g] = q;
  end

  assign rd_data_a = word[rd_addr_a];
  assign rd_data_b = word[rd_addr_b];
endmodule

module regfile_idx_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [DATA_W-1:0] rd_data_b
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  AST_ZERO_WORD_A: assert property (@(posedge clk) disable iff (rst || !armed)
    (rd_addr_a == '0) |-> (rd_data_a == '0)); // R3
  AST_ZERO_WORD_B: assert property (@(posedge clk) disable iff (rst || !armed)
    (rd_addr_b == '0) |-> (rd_data_b == '0)); // R3
  AST_RESET_INDEX: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> (rd_data_a == ((rd_addr_a == '0) ? '0 : DATA_W'(rd_addr_a)))); // R2
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wr_en && wr_addr != '0 && !rst) && rd_addr_b == $past(wr_addr))
    |-> (rd_data_b == $past(wr_data))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(!wr_en || wr_addr != rd_addr_a) && $stable(rd_addr_a))
    |-> $stable(rd_data_a)); // R5
endmodule

bind regfile_idx regfile_idx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
  .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
);

// File: tb/regfile_idx_test.sv
module regfile_idx_test;
  localparam int PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr_a = '0;
  logic [4:0] rd_addr_b = '0;
  logic [7:0] rd_data_a, rd_data_b;

  regfile_idx uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    string    tag;
    bit       port_b;
    bit [7:0] exp;
  } item_t;

  item_t      sb[$];
  logic [7:0] model [32];
  bit         model_ok = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  // Driver: applies one cycle of stimulus and queues the expected reads.
  task automatic step(input bit r, input bit we, input logic [4:0] wa,
                      input logic [7:0] wd, input logic [4:0] ra,
                      input logic [4:0] rb, input string tag);
    @(posedge clk); #1;
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_addr_a = ra; rd_addr_b = rb;
    if (model_ok) begin
      sb.push_back('{tag, 1'b0, model[ra]});
      sb.push_back('{tag, 1'b1, model[rb]});
    end
    if (r) begin
      for (int n = 0; n < 32; n++) model[n] = 8'(n);
      model_ok = 1;
    end else if (we && wa != 0) begin
      model[wa] = wd;
    end
    model[0] = 8'h00;
  endtask

  // Monitor: compares queued expectations mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb.pop_front();
        got = it.port_b ? rd_data_b : rd_data_a;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s port %s: got %h expected %h", it.tag,
                   it.port_b ? "B" : "A", got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 0, 0, "init");
    // R2 R3 R7: reset pattern on both ports, opposite orders
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 5'(i), 5'(31 - i), "R2 R3 R7");
    // R8 R6: write each address while reading it (old value expected)
    for (int i = 0; i < 32; i++)
      step(0, 1, 5'(i), 8'(8'hA5 ^ (i * 7)), 5'(i), 5'(i + 1), "R8 R6");
    // R1 R4 R7: read back every word on both ports at the same address
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 5'(i), 5'(i), "R1 R4 R7");
    // R5: enable low, address and data present
    step(0, 0, 5'd5, 8'hFF, 5'd5, 5'd6, "R5");
    step(0, 0, 0, 0, 5'd5, 5'd6, "R5");
    // R6 R3: write nonzero data to address 0
    step(0, 1, 5'd0, 8'h77, 5'd0, 5'd0, "R6 R3");
    step(0, 0, 0, 0, 5'd0, 5'd0, "R6 R3");
    // R10: reset raised with a write; old values visible before the edge
    step(1, 1, 5'd9, 8'h55, 5'd9, 5'd12, "R10");
    // R9: reset beat the write; R2 again after second reset
    step(0, 0, 0, 0, 5'd9, 5'd12, "R9 R2");
    // R4 R7: write then read on both ports
    step(0, 1, 5'd31, 8'h3C, 5'd31, 5'd1, "R8");
    step(0, 0, 0, 0, 5'd1, 5'd31, "R4 R7");
    step(0, 0, 0, 0, 0, 0, "drain");
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule